// File: doc/BRIEF.md
# Burst Address Sequencer with Linear and Interleaved Order

This block turns one supplied address into a run of up to four accesses. A single control pin picks between taking a new address from the inputs and stepping the current burst. A two-bit counter moves the low address bits through the burst, while the upper bits stay as they were loaded. A mode input, captured at load time, picks the order. In linear order the low bits count up and wrap modulo four. In interleaved order they are the starting low bits XOR the step count.

Each enabled clock edge produces one registered access descriptor. It holds the full effective address, a valid flag and the read/write direction. A continuation flag is set on every access after the first of a burst; it tells the access to keep the burst's direction rather than sample a new one. A deselect ends the burst. A step request that arrives while no burst is open is treated as a continued deselect. When the clock enable is low, every register holds.

Top module: `burst_seq`

## Requirements
- R1: After reset, acc_valid, acc_write and burst_cont are 0 and eff_addr is all zeros.
- R2: On an enabled edge with adv_ld=0 and sel=1, the next outputs are eff_addr=addr_in, acc_valid=1, acc_write=wr_en and burst_cont=0. This edge also captures order_mode.
- R3: With order_mode=0 captured (linear), the k-th step after a load gives low bits (start+k) mod 4. For example, a start of 2 gives 2,3,0,1.
- R4: With order_mode=1 captured (interleaved), the k-th step after a load gives low bits start XOR k. For example, a start of 1 gives 1,0,3,2.
- R5: The step after the fourth access wraps back to the starting low bits, and the sequence repeats.
- R6: During steps the upper address bits (above the low two) equal the loaded ones. addr_in is ignored on every step.
- R7: Every step (adv_ld=1 with a burst open) gives acc_valid=1, burst_cont=1 and acc_write equal to the wr_en captured at load. wr_en is ignored on a step.
- R8: On an enabled edge with adv_ld=0 and sel=0, the next outputs are acc_valid=0, acc_write=0 and burst_cont=0.
- R9: A step request (adv_ld=1) while no burst is open, whether after reset or after a deselect, leaves acc_valid=0 and burst_cont=0.
- R10: While clk_en=0, all outputs and the burst position hold. When clk_en returns, the sequence resumes from the step where it stopped.
- R11: A change of order_mode during a burst has no effect until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | Clock enable; low freezes the block |
| sel | input | 1 | Access request, sampled when adv_ld=0 |
| adv_ld | input | 1 | 0 = load new address, 1 = step current burst |
| order_mode | input | 1 | 0 = linear, 1 = interleaved; captured at load |
| wr_en | input | 1 | Direction of the burst, captured at load (1 = write) |
| addr_in | input | AW | External start address |
| eff_addr | output | AW | Effective address of the current access |
| acc_valid | output | 1 | Current access is valid |
| acc_write | output | 1 | Current access is a write |
| burst_cont | output | 1 | Access continues a burst and keeps its direction |

## Verification
The bench sweeps every start value in both orders and for both directions, running six steps so the wrap back to the start is observed. A sequencer that kept counting past four, or mixed up add and XOR, would give wrong low bits at the third step or the wrap. During steps the bench drives a different address, the opposite direction and the opposite mode, to catch a design that samples any of these outside a load. It also sends step requests right after reset and after a deselect. A design that reused a stale burst there would raise acc_valid. Clock-enable gaps inside a burst check that a design neither skips nor repeats a step.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
   typedef enum logic [1:0] {
      OP_HOLD  = 2'd0,
      OP_LOAD  = 2'd1,
      OP_ADV   = 2'd2,
      OP_DESEL = 2'd3
   } seq_op_t;

   typedef enum logic {
      ORD_LINEAR     = 1'b0,
      ORD_INTERLEAVE = 1'b1
   } ord_t;
endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
   import burst_seq_pkg::*;
(
   input  logic    clk_en,
   input  logic    sel,
   input  logic    adv_ld,
   input  logic    open_burst,
   output seq_op_t op
);
   always_comb begin
      if (!clk_en)
         op = OP_HOLD;
      else if (!adv_ld)
         op = sel ? OP_LOAD : OP_DESEL;
      else
         op = open_burst ? OP_ADV : OP_DESEL;
   end
endmodule

// File: rtl/burst_seq_count.sv
module burst_seq_count
   import burst_seq_pkg::*;
#(
   parameter int BB = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  seq_op_t       op,
   output logic [BB-1:0] cnt_adv
);
   logic [BB-1:0] cnt_q;

   assign cnt_adv = cnt_q + {{(BB-1){1'b0}}, 1'b1};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else begin
         case (op)
            OP_LOAD: cnt_q <= '0;
            OP_ADV:  cnt_q <= cnt_adv;
            default: cnt_q <= cnt_q;
         endcase
      end
   end
endmodule

// File: rtl/burst_seq_order.sv
module burst_seq_order
   import burst_seq_pkg::*;
#(
   parameter int BB             = 2,
   parameter bit HAS_INTERLEAVE = 1'b1
) (
   input  logic [BB-1:0] start,
   input  logic [BB-1:0] step,
   input  ord_t          mode,
   output logic [BB-1:0] low
);
   generate
      if (HAS_INTERLEAVE) begin : g_both
         always_comb begin
            if (mode == ORD_INTERLEAVE)
               low = start ^ step;
            else
               low = start + step;
         end
      end else begin : g_linear_only
         ord_t unused_mode;
         assign unused_mode = mode;
         assign low = start + step;
      end
   endgenerate
endmodule

// File: rtl/burst_seq.sv
module burst_seq
   import burst_seq_pkg::*;
#(
   parameter int AW             = 17,
   parameter int BB             = 2,
   parameter bit HAS_INTERLEAVE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clk_en,
   input  logic          sel,
   input  logic          adv_ld,
   input  logic          order_mode,
   input  logic          wr_en,
   input  logic [AW-1:0] addr_in,
   output logic [AW-1:0] eff_addr,
   output logic          acc_valid,
   output logic          acc_write,
   output logic          burst_cont
);
   localparam int UPW = AW - BB;

   initial begin
      assert (BB >= 1 && BB <= 4) else $error("burst_seq: BB must be 1..4");
      assert (UPW >= 1) else $error("burst_seq: AW must exceed BB");
   end

   seq_op_t       op;
   logic [BB-1:0] cnt_adv;
   logic [BB-1:0] low_nxt;
   logic [AW-1:0] base_q;
   ord_t          mode_q;
   logic          dir_q;
   logic [AW-1:0] eff_q;
   logic          valid_q;
   logic          wr_q;
   logic          cont_q;

   burst_seq_ctrl u_ctrl (
      .clk_en     (clk_en),
      .sel        (sel),
      .adv_ld     (adv_ld),
      .open_burst (valid_q),
      .op         (op)
   );

   burst_seq_count #(.BB(BB)) u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .op      (op),
      .cnt_adv (cnt_adv)
   );

   burst_seq_order #(.BB(BB), .HAS_INTERLEAVE(HAS_INTERLEAVE)) u_order (
      .start (base_q[BB-1:0]),
      .step  (cnt_adv),
      .mode  (mode_q),
      .low   (low_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q  <= '0;
         mode_q  <= ORD_LINEAR;
         dir_q   <= 1'b0;
         eff_q   <= '0;
         valid_q <= 1'b0;
         wr_q    <= 1'b0;
         cont_q  <= 1'b0;
      end else begin
         case (op)
            OP_LOAD: begin
               base_q  <= addr_in;
               mode_q  <= ord_t'(order_mode);
               dir_q   <= wr_en;
               eff_q   <= addr_in;
               valid_q <= 1'b1;
               wr_q    <= wr_en;
               cont_q  <= 1'b0;
            end
            OP_ADV: begin
               eff_q   <= {base_q[AW-1:BB], low_nxt};
               valid_q <= 1'b1;
               wr_q    <= dir_q;
               cont_q  <= 1'b1;
            end
            OP_DESEL: begin
               valid_q <= 1'b0;
               wr_q    <= 1'b0;
               cont_q  <= 1'b0;
            end
            default: begin
               valid_q <= valid_q;
            end
         endcase
      end
   end

   assign eff_addr   = eff_q;
   assign acc_valid  = valid_q;
   assign acc_write  = wr_q;
   assign burst_cont = cont_q;
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
   parameter int AW = 17,
   parameter int BB = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          clk_en,
   input logic          sel,
   input logic          adv_ld,
   input logic          wr_en,
   input logic [AW-1:0] addr_in,
   input logic [AW-1:0] eff_addr,
   input logic          acc_valid,
   input logic          acc_write,
   input logic          burst_cont
);
   AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en |=> $stable(eff_addr) && $stable(acc_valid) && $stable(acc_write) && $stable(burst_cont)); // R10

   AST_LOAD_TAKES_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en && !adv_ld && sel |=> acc_valid && !burst_cont && eff_addr == $past(addr_in) && acc_write == $past(wr_en)); // R2

   AST_DESELECT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en && !adv_ld && !sel |=> !acc_valid && !acc_write && !burst_cont); // R8

   AST_IDLE_STEP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en && adv_ld && !acc_valid |=> !acc_valid && !burst_cont); // R9

   AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en && adv_ld && acc_valid |=> acc_valid && burst_cont && eff_addr[AW-1:BB] == $past(eff_addr[AW-1:BB])); // R6

   AST_DIR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en && adv_ld && acc_valid |=> acc_write == $past(acc_write)); // R7

   AST_LOW_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en && adv_ld && acc_valid |=> eff_addr[BB-1:0] != $past(eff_addr[BB-1:0])); // R3
endmodule

bind burst_seq burst_seq_chk #(.AW(AW), .BB(BB)) u_burst_seq_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .clk_en     (clk_en),
   .sel        (sel),
   .adv_ld     (adv_ld),
   .wr_en      (wr_en),
   .addr_in    (addr_in),
   .eff_addr   (eff_addr),
   .acc_valid  (acc_valid),
   .acc_write  (acc_write),
   .burst_cont (burst_cont)
);

// File: tb/burst_seq_bench.sv
module burst_seq_bench;
   localparam int AW   = 6;
   localparam int BB   = 2;
   localparam int BLEN = 1 << BB;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clk_en = 1'b0;
   logic          sel = 1'b0;
   logic          adv_ld = 1'b0;
   logic          order_mode = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] addr_in = '0;
   logic [AW-1:0] eff_addr;
   logic          acc_valid;
   logic          acc_write;
   logic          burst_cont;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   int            m_base;
   int            m_cnt;
   bit            m_open;
   bit            m_dir;
   bit            m_mode;
   bit            e_valid;
   bit            e_wr;
   bit            e_cont;
   int            e_addr;

   always #10 clk = ~clk;

   burst_seq #(.AW(AW), .BB(BB)) u_burst_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .clk_en     (clk_en),
      .sel        (sel),
      .adv_ld     (adv_ld),
      .order_mode (order_mode),
      .wr_en      (wr_en),
      .addr_in    (addr_in),
      .eff_addr   (eff_addr),
      .acc_valid  (acc_valid),
      .acc_write  (acc_write),
      .burst_cont (burst_cont)
   );

   task automatic check(input string tag);
      checks++;
      if (acc_valid !== e_valid || acc_write !== e_wr || burst_cont !== e_cont ||
          (e_valid && eff_addr !== e_addr[AW-1:0])) begin
         errors++;
         $display("FAIL %s: got v=%0b w=%0b c=%0b a=%0d, expected v=%0b w=%0b c=%0b a=%0d",
                  tag, acc_valid, acc_write, burst_cont, eff_addr, e_valid, e_wr, e_cont, e_addr);
      end
   endtask

   task automatic step(input bit s, input bit a, input bit m, input bit w, input bit ce,
                       input int ad, input string tag);
      int lo;
      sel = s; adv_ld = a; order_mode = m; wr_en = w; clk_en = ce; addr_in = ad[AW-1:0];
      @(posedge clk);
      if (ce) begin
         if (!a && s) begin
            m_base = ad % (1 << AW); m_cnt = 0; m_open = 1; m_dir = w; m_mode = m;
            e_valid = 1; e_wr = w; e_cont = 0; e_addr = m_base;
         end else if (a && m_open) begin
            m_cnt = (m_cnt + 1) % BLEN;
            if (m_mode) lo = (m_base % BLEN) ^ m_cnt;
            else        lo = ((m_base % BLEN) + m_cnt) % BLEN;
            e_addr = (m_base / BLEN) * BLEN + lo;
            e_valid = 1; e_wr = m_dir; e_cont = 1;
         end else begin
            m_open = 0; e_valid = 0; e_wr = 0; e_cont = 0;
         end
      end
      @(negedge clk);
      check(tag);
   endtask

   initial begin
      m_base = 0; m_cnt = 0; m_open = 0; m_dir = 0; m_mode = 0;
      e_valid = 0; e_wr = 0; e_cont = 0; e_addr = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check("R1 reset state");
      if (eff_addr !== '0) begin
         checks++; errors++;
         $display("FAIL R1: eff_addr got %0d expected 0", eff_addr);
      end else checks++;

      step(0, 1, 0, 0, 1, 5, "R9 step after reset");
      step(0, 1, 1, 1, 1, 9, "R9 second step after reset");

      for (int m = 0; m < 2; m++) begin
         for (int st = 0; st < BLEN; st++) begin
            for (int w = 0; w < 2; w++) begin
               int ad;
               ad = (((st * 5 + m * 3 + w * 7) % 16) * BLEN) + st;
               step(1, 0, bit'(m), bit'(w), 1, ad, "R2 load");
               for (int k = 1; k <= BLEN + 1; k++) begin
                  step(1, 1, bit'(1 - m), bit'(1 - w), 1, ad ^ 6'h3C ^ k,
                       k < BLEN ? (m ? "R4 R6 R7 R11 interleaved step" : "R3 R6 R7 R11 linear step")
                                : "R5 wrap to start");
               end
            end
         end
      end

      step(1, 0, 0, 1, 1, 6'h2A, "R2 load for freeze");
      step(1, 1, 0, 0, 1, 0, "R3 first step");
      step(0, 0, 1, 0, 0, 6'h11, "R10 frozen deselect");
      step(1, 0, 1, 0, 0, 6'h07, "R10 frozen load");
      step(1, 1, 1, 0, 0, 6'h07, "R10 frozen step");
      step(1, 1, 0, 0, 1, 0, "R10 resume step");
      step(1, 1, 0, 0, 1, 0, "R10 resume wrap side");

      step(0, 0, 0, 0, 1, 0, "R8 deselect");
      step(1, 1, 0, 1, 1, 6'h15, "R9 step after deselect");
      step(0, 1, 0, 0, 1, 6'h15, "R9 step after deselect again");
      step(1, 0, 1, 0, 1, 6'h21, "R2 load interleaved");
      step(0, 1, 0, 1, 1, 0, "R4 start 1 step");
      step(0, 1, 0, 1, 1, 0, "R4 start 1 step");
      step(0, 1, 0, 1, 1, 0, "R4 start 1 step");
      step(0, 0, 0, 0, 1, 0, "R8 deselect mid burst");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int c = 0; c < 20000; c++) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule